// File: doc/BRIEF.md
# Level-Request Interrupt Combiner

This block merges a bank of interrupt request lines into one interrupt toward a processor. Each request line passes through a synchronizer. A rising edge on the synchronized line marks that line pending, and a falling edge removes the mark. A line collects pending state even while software has it masked off. A software-owned enable word gates the pending word. When any line is both pending and enabled, the combined output goes high one clock later.

Software reaches the block through a small 32-bit register port with APB-style setup and access phases. One register reports how many lines are currently pending and enabled. A second returns the pending word after masking with the enable word. Two write-only registers set or clear selected enable bits, and a third write-only register wipes all pending and enable state in a single access. Read data is captured at the setup edge and stays valid for the whole access phase. Every access is a full 32-bit word.

Top module: `irq_line_merger`

## Requirements
- R1: After synchronous reset, the pending word and the enable word are zero, `cpu_irq` is low and `bus_rdata` is zero.
- R2: A request line sampled high at clock edge k, after being sampled low at edge k-1, sets its pending bit at edge k+2, whether or not the line is enabled.
- R3: A request line sampled low at edge k, after being sampled high at edge k-1, clears its pending bit at edge k+2.
- R4: A write to offset 0x10 sets each enable bit whose data bit is 1 and leaves every other enable bit unchanged.
- R5: A write to offset 0x0C clears each enable bit whose data bit is 1 and leaves every other enable bit unchanged.
- R6: Any write to offset 0x08, whatever its data, clears every pending and every enable bit. A line still held high afterwards stays not pending until it falls and rises again. When a line edge reaches the pending word in the same cycle as this write, the write wins.
- R7: A read of offset 0x04 returns the pending word ANDed with the enable word, with bit n holding line n.
- R8: A read of offset 0x00 returns, zero-extended, the number of lines that are both pending and enabled, from 0 to 32.
- R9: `cpu_irq` is a register. At each clock edge it takes the OR of (pending AND enable) as they stood just before that edge.
- R10: A read of any offset other than 0x00 and 0x04, misaligned offsets included, returns zero. A write to any offset other than 0x08, 0x0C and 0x10 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_lines | input | NUM_LINES | Asynchronous interrupt request lines, one bit per line |
| bus_sel | input | 1 | Register port select |
| bus_en | input | 1 | Access phase marker (low in the setup phase) |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid throughout the access phase |
| cpu_irq | output | 1 | Combined registered interrupt output |

## Verification
Two functions can meet in one cycle. A synchronized line edge can update the pending word on the same edge where a bus write changes the enable word or wipes all state. The bench provokes the worst case on purpose: it raises a line exactly two edges before a wipe's access edge, so the rising edge and the wipe land together. It then re-enables every line and reads the masked word, which must show the line as not pending. A long random phase afterwards toggles lines while it issues interleaved writes and reads. A behavioural model judges every cycle of `cpu_irq` and every read, and it resolves all same-edge collisions with the priorities stated in R6 and R9.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

  localparam int unsigned BUS_W = 32;

  // Register offsets (byte addresses, word-aligned)
  localparam logic [31:0] OFF_COUNT  = 32'h00;
  localparam logic [31:0] OFF_MASKED = 32'h04;
  localparam logic [31:0] OFF_WIPE   = 32'h08;
  localparam logic [31:0] OFF_CLR    = 32'h0C;
  localparam logic [31:0] OFF_SET    = 32'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_COUNT,
    SEL_MASKED,
    SEL_WIPE,
    SEL_CLR,
    SEL_SET
  } reg_sel_e;

  // Full-address compare: misaligned or unmapped offsets decode to SEL_NONE.
  function automatic reg_sel_e decode_offset(input logic [31:0] a);
    reg_sel_e s;
    case (a)
      OFF_COUNT:  s = SEL_COUNT;
      OFF_MASKED: s = SEL_MASKED;
      OFF_WIPE:   s = SEL_WIPE;
      OFF_CLR:    s = SEL_CLR;
      OFF_SET:    s = SEL_SET;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/irqm_sync.sv
module irqm_sync #(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_async,
  output logic [NUM_LINES-1:0] rise,
  output logic [NUM_LINES-1:0] fall
);

  // One extra stage beyond the synchronizer holds the previous value
  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '0;
      end else begin
        chain_q <= {chain_q[CHAIN_W-2:0], req_async[g]};
      end
    end

    assign rise[g] =  chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    assign fall[g] = ~chain_q[SYNC_STAGES-1] &  chain_q[SYNC_STAGES];
  end

endmodule

// File: rtl/irqm_state.sv
module irqm_state #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] rise,
  input  logic [NUM_LINES-1:0] fall,
  input  logic                 wipe_stb,
  input  logic                 set_stb,
  input  logic                 clr_stb,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] pend,
  output logic [NUM_LINES-1:0] en
);

  logic [NUM_LINES-1:0] pend_q, en_q;
  logic [NUM_LINES-1:0] pend_d, en_d;

  always_comb begin
    pend_d = (pend_q | rise) & ~fall;
    en_d   = en_q;
    if (set_stb) en_d = en_d | wdata;
    if (clr_stb) en_d = en_d & ~wdata;
    // The wipe command overrides any line edge landing on the same edge
    if (wipe_stb) begin
      pend_d = '0;
      en_d   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  assign pend = pend_q;
  assign en   = en_q;

  // R6
  wipe_clears_chk: assert property (@(posedge clk) disable iff (rst)
    wipe_stb |=> (pend_q == '0 && en_q == '0));

  // R4
  set_bits_chk: assert property (@(posedge clk) disable iff (rst)
    set_stb |=> ((en_q & $past(wdata)) == $past(wdata)));

  // R5
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    clr_stb |=> ((en_q & $past(wdata)) == '0));

  // R2
  rise_pend_chk: assert property (@(posedge clk) disable iff (rst)
    ((|rise) && !wipe_stb) |=> ((pend_q & $past(rise)) == $past(rise)));

  // R3
  fall_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (|fall) |=> ((pend_q & $past(fall)) == '0));

endmodule

// File: rtl/irqm_popcnt.sv
module irqm_popcnt #(
  parameter int unsigned NUM_LINES = 32,
  localparam int unsigned CNT_W    = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] vec,
  output logic [CNT_W-1:0]     cnt
);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      cnt = cnt + CNT_W'(vec[i]);
    end
  end

  // R8
  cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((cnt == '0) == (vec == '0)));

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt <= CNT_W'(NUM_LINES)));

endmodule

// File: rtl/irq_line_merger.sv
module irq_line_merger
  import irqm_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_lines,
  input  logic                 bus_sel,
  input  logic                 bus_en,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic                 cpu_irq
);

  localparam int unsigned CNT_W = $clog2(NUM_LINES + 1);

  logic [NUM_LINES-1:0] rise, fall, pend, en, active;
  logic [CNT_W-1:0]     cnt;
  logic [31:0]          addr_ext;
  reg_sel_e             sel;
  logic                 wr_access, rd_setup;
  logic                 wipe_stb, set_stb, clr_stb;
  logic [BUS_W-1:0]     rdata_q;
  logic                 irq_q;

  irqm_sync #(
    .NUM_LINES  (NUM_LINES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .req_async(req_lines),
    .rise     (rise),
    .fall     (fall)
  );

  assign addr_ext  = 32'(bus_addr);
  assign sel       = decode_offset(addr_ext);
  assign wr_access = bus_sel & bus_en & bus_wr;
  assign rd_setup  = bus_sel & ~bus_en & ~bus_wr;
  assign wipe_stb  = wr_access && (sel == SEL_WIPE);
  assign set_stb   = wr_access && (sel == SEL_SET);
  assign clr_stb   = wr_access && (sel == SEL_CLR);

  irqm_state #(
    .NUM_LINES(NUM_LINES)
  ) u_state (
    .clk     (clk),
    .rst     (rst),
    .rise    (rise),
    .fall    (fall),
    .wipe_stb(wipe_stb),
    .set_stb (set_stb),
    .clr_stb (clr_stb),
    .wdata   (bus_wdata[NUM_LINES-1:0]),
    .pend    (pend),
    .en      (en)
  );

  assign active = pend & en;

  irqm_popcnt #(
    .NUM_LINES(NUM_LINES)
  ) u_cnt (
    .clk(clk),
    .rst(rst),
    .vec(active),
    .cnt(cnt)
  );

  // Read data is captured at the setup edge and held through the access phase
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_setup) begin
      case (sel)
        SEL_COUNT:  rdata_q <= BUS_W'(cnt);
        SEL_MASKED: rdata_q <= BUS_W'(active);
        default:    rdata_q <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |active;
  end

  assign bus_rdata = rdata_q;
  assign cpu_irq   = irq_q;

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cpu_irq == $past(|(pend & en))));

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_setup && sel != SEL_COUNT && sel != SEL_MASKED) |=> (bus_rdata == '0));

endmodule

// File: tb/sim_irq_line_merger.sv
`timescale 1ns/1ps
module sim_irq_line_merger;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req_lines = '0;
  logic          bus_sel = 1'b0, bus_en = 1'b0, bus_wr = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          cpu_irq;

  always #2.5 clk = ~clk;

  irq_line_merger #(.NUM_LINES(N), .ADDR_W(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .req_lines(req_lines),
    .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Behavioural reference model
  logic [N-1:0] m_pend, m_en, m_r, m_f;
  logic         exp_irq;
  logic [31:0]  exp_rd;
  logic [N-1:0] hist[$];
  bit           m_wr;

  always @(posedge clk) begin
    if (rst) begin
      m_pend = '0; m_en = '0; exp_irq = 1'b0; exp_rd = '0;
      hist = '{'0, '0, '0};
    end else begin
      // line edge seen two edges after the sample that carries it
      m_r = hist[1] & ~hist[2];
      m_f = ~hist[1] & hist[2];
      exp_irq = |(m_pend & m_en);
      if (bus_sel && !bus_en && !bus_wr) begin
        if (bus_addr == 8'h00)      exp_rd = 32'($countones(m_pend & m_en));
        else if (bus_addr == 8'h04) exp_rd = 32'(m_pend & m_en);
        else                        exp_rd = '0;
      end
      m_wr = bus_sel && bus_en && bus_wr;
      if (m_wr && bus_addr == 8'h08) begin
        m_pend = '0; m_en = '0;
      end else begin
        m_pend = (m_pend | m_r) & ~m_f;
        if (m_wr && bus_addr == 8'h0C) m_en = m_en & ~bus_wdata;
        if (m_wr && bus_addr == 8'h10) m_en = m_en | bus_wdata;
      end
      hist.push_front(req_lines);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // R9: output compared against the model on every cycle
  always @(negedge clk) begin
    if (!rst && !done) chk(32'(cpu_irq), 32'(exp_irq), "R9 cpu_irq");
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  // Reads compare against the model; directed reads also against a fixed value
  task automatic rd(input logic [7:0] a, input bit fixed, input logic [31:0] val, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b1;
    @(negedge clk);
    chk(bus_rdata, exp_rd, tag);
    if (fixed) chk(bus_rdata, val, tag);
    bus_sel = 1'b0; bus_en = 1'b0;
  endtask

  task automatic lines(input logic [N-1:0] v);
    @(negedge clk);
    req_lines = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(32'(cpu_irq), 32'h0, "R1 irq in reset");
    chk(bus_rdata, 32'h0, "R1 rdata in reset");
    rst = 1'b0;
    rd(8'h00, 1, 32'd0, "R1 R8 count after reset");
    rd(8'h04, 1, 32'h0, "R1 R7 masked after reset");

    // pending recorded while masked
    lines(32'h21);
    rd(8'h04, 1, 32'h0, "R2 masked while disabled");
    chk(32'(cpu_irq), 32'h0, "R2 no irq while disabled");
    wr(8'h10, 32'h21);
    repeat (2) @(negedge clk);
    rd(8'h04, 1, 32'h21, "R2 R4 pending kept while disabled");
    rd(8'h00, 1, 32'd2, "R8 count two");
    chk(32'(cpu_irq), 32'h1, "R9 irq high");

    wr(8'h0C, 32'h1);
    rd(8'h04, 1, 32'h20, "R5 clear one bit only");
    wr(8'h10, 32'h100);
    rd(8'h04, 1, 32'h20, "R4 enable without pending");

    lines(32'h01);
    rd(8'h04, 1, 32'h0, "R3 falling line cleared");
    repeat (2) @(negedge clk);
    chk(32'(cpu_irq), 32'h0, "R9 irq low");
    wr(8'h10, 32'h1);
    rd(8'h04, 1, 32'h1, "R2 held line pending");

    lines('1);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h00, 1, 32'd32, "R8 full count");
    rd(8'h04, 1, 32'hFFFF_FFFF, "R7 all masked");

    wr(8'h08, 32'h0);
    rd(8'h04, 1, 32'h0, "R6 wipe pending");
    rd(8'h00, 1, 32'd0, "R6 wipe count");
    wr(8'h10, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    rd(8'h04, 1, 32'h0, "R6 held line stays clear");
    lines(~32'h8);
    lines('1);
    rd(8'h04, 1, 32'h8, "R6 re-rise pends again");

    // collision: line 7 rise reaches the state on the wipe's access edge
    lines(~32'h80);
    @(negedge clk);
    req_lines[7] = 1'b1;
    wr(8'h08, 32'hA5A5_A5A5);
    wr(8'h10, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    rd(8'h04, 1, 32'h0, "R6 wipe beats same-cycle rise");

    // unmapped offsets
    lines('0);
    lines(32'hF0);
    rd(8'h04, 1, 32'hF0, "R7 masked before unmapped writes");
    wr(8'h14, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    wr(8'h0D, 32'hFFFF_FFFF);
    wr(8'h09, 32'h0);
    rd(8'h04, 1, 32'hF0, "R10 unmapped writes ignored");
    rd(8'h08, 1, 32'h0, "R10 read wipe reg");
    rd(8'h0C, 1, 32'h0, "R10 read clear reg");
    rd(8'h10, 1, 32'h0, "R10 read set reg");
    rd(8'h20, 1, 32'h0, "R10 read beyond map");
    rd(8'h05, 1, 32'h0, "R10 misaligned read");

    // random interleaving judged by the model
    fork
      begin
        repeat (3000) begin
          @(negedge clk);
          req_lines = req_lines ^ ($urandom & $urandom & $urandom);
        end
      end
      begin
        repeat (400) begin
          automatic int pick = $urandom_range(0, 19);
          automatic logic [31:0] d = $urandom;
          case (pick)
            0:            wr(8'h08, d);
            1, 2, 3:      wr(8'h10, d);
            4, 5, 6:      wr(8'h0C, d & $urandom);
            7:            wr(8'h14, d);
            8, 9, 10, 11: rd(8'h04, 0, 32'h0, "R7 random masked read");
            12, 13, 14:   rd(8'h00, 0, 32'h0, "R8 random count read");
            15:           rd(8'h0C, 0, 32'h0, "R10 random unmapped read");
            default:      repeat ($urandom_range(1, 5)) @(negedge clk);
          endcase
        end
      end
    join

    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule